// File: doc/BRIEF.md
# Boundary-Scan Cell Chain with Internal-Test Capture

This block is a parameterised serial chain of boundary-scan cells. It sits between N pin inputs and the core, and between M core outputs and the output pins. Each cell has a shift stage clocked on the rising edge of the test clock and an update latch loaded on the falling edge. A separately built test access port controller drives the capture, shift and update strobes, the test-mode select and the global output-disable.

In normal mode, data passes straight from the pins to the core and from the core to the pins. A vector can still be shifted in and committed to the update latches, so known values are in place when test mode is entered. In test mode, the update latches drive the core inputs and the output pins. A capture step then records the complement of the value each input cell feeds to the core, and the true value the core is driving on each output cell. While output-disable is asserted, the pins are not enabled, but the output data still comes from the update latches.

Top module: `bscan_chain`

## Requirements
- R1: While `rst_ni` is low, every shift stage and every update latch is cleared to 0. With `test_mode_i`=1 after reset, `core_in_o`, `pin_out_o` and `tdo_o` all read 0.
- R2: With `test_mode_i`=0 and `out_dis_i`=0, `core_in_o` equals `pin_in_i`, `pin_out_o` equals `core_out_i`, and `pin_oe_o` is 1.
- R3: With `test_mode_i`=1, `core_in_o[i]` is driven by the update latch at chain index i, and `pin_out_o[j]` by the update latch at chain index N+j.
- R4: A capture with `test_mode_i`=1 loads each input cell with the inverse of its current `core_in_o` bit, and each output cell with its `core_out_i` bit.
- R5: A capture with `test_mode_i`=0 loads each input cell with its `pin_in_i` bit, and each output cell with its `core_out_i` bit.
- R6: Chain index 0 is input cell 0, which is nearest `tdi_i`. Output cell M-1, at chain index N+M-1, drives `tdo_o`. Each rising edge with `shift_dr_i`=1 moves every bit one index toward `tdo_o` and loads `tdi_i` into index 0.
- R7: The update latches load the shift stages only on a falling edge with `update_dr_i`=1. Otherwise they hold, and the outputs they drive in test mode do not change during capture or shift.
- R8: An update performed with `test_mode_i`=0 leaves `core_in_o` and `pin_out_o` in pass-through. The committed vector then appears on them as soon as `test_mode_i` goes to 1, with no further strobe.
- R9: While `out_dis_i`=1, `pin_oe_o` is 0 and `pin_out_o` is driven from the update latches, whatever the value of `test_mode_i`.
- R10: When `capture_dr_i` and `shift_dr_i` are both 1 on the same edge, the capture takes effect and the shift does not.
- R11: With `capture_dr_i`=0 and `shift_dr_i`=0, the shift stages hold their contents across any number of edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock; shift stages on the rising edge, update latches on the falling edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| capture_dr_i | input | 1 | Capture strobe |
| shift_dr_i | input | 1 | Shift strobe |
| update_dr_i | input | 1 | Update strobe |
| test_mode_i | input | 1 | 1: cells drive the core and pins from their update latches |
| out_dis_i | input | 1 | Global output-disable |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, from the last cell |
| pin_in_i | input | N_IN | Values arriving from the input pins |
| core_in_o | output | N_IN | Values presented to the core inputs |
| core_out_i | input | M_OUT | Values the core drives out |
| pin_out_o | output | M_OUT | Data to the output pad drivers |
| pin_oe_o | output | 1 | Output pad enable |

## Verification
The hardest case to reach from the ports is the inverted capture on the input cells. The captured value depends on what the update latch is feeding the core at that moment, and that value can only be set by a full shift and update beforehand. For every possible chain vector, the bench first preloads the vector in normal mode, then enters test mode and captures. It shifts the result out while shifting a second vector in, and checks the serial stream against the inverted input slice joined to the output pattern it is presenting. It also checks that the core-side values do not move until the second update lands.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
    logic test_mode;
  } bs_ctrl_t;

  typedef enum logic [1:0] {
    SR_HOLD  = 2'd0,
    SR_LOAD  = 2'd1,
    SR_SHIFT = 2'd2
  } sr_op_e;

  // capture wins over shift
  function automatic sr_op_e sr_op(bs_ctrl_t c);
    if (c.capture)    return SR_LOAD;
    else if (c.shift) return SR_SHIFT;
    else              return SR_HOLD;
  endfunction

endpackage

// File: rtl/bscan_stage.sv
module bscan_stage
  import bscan_pkg::*;
(
  input  logic     tck_i,
  input  logic     rst_ni,
  input  bs_ctrl_t ctrl_i,
  input  logic     cap_i,
  input  logic     ser_i,
  output logic     ser_o,
  output logic     upd_o
);

  logic sr_q;
  logic upd_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= 1'b0;
    end else begin
      unique case (sr_op(ctrl_i))
        SR_LOAD:  sr_q <= cap_i;
        SR_SHIFT: sr_q <= ser_i;
        default:  sr_q <= sr_q;
      endcase
    end
  end

  // update latch on the falling edge
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni)           upd_q <= 1'b0;
    else if (ctrl_i.update) upd_q <= sr_q;
  end

  assign ser_o = sr_q;
  assign upd_o = upd_q;

endmodule

// File: rtl/bscan_in_cell.sv
module bscan_in_cell
  import bscan_pkg::*;
(
  input  logic     tck_i,
  input  logic     rst_ni,
  input  bs_ctrl_t ctrl_i,
  input  logic     pin_i,
  input  logic     ser_i,
  output logic     ser_o,
  output logic     core_o
);

  logic upd;
  logic cap;

  // internal test captures the inverse of what the core sees
  assign cap    = ctrl_i.test_mode ? ~core_o : pin_i;
  assign core_o = ctrl_i.test_mode ? upd : pin_i;

  bscan_stage u_stage (
    .tck_i  (tck_i),
    .rst_ni (rst_ni),
    .ctrl_i (ctrl_i),
    .cap_i  (cap),
    .ser_i  (ser_i),
    .ser_o  (ser_o),
    .upd_o  (upd)
  );

endmodule

// File: rtl/bscan_out_cell.sv
module bscan_out_cell
  import bscan_pkg::*;
(
  input  logic     tck_i,
  input  logic     rst_ni,
  input  bs_ctrl_t ctrl_i,
  input  logic     out_dis_i,
  input  logic     core_i,
  input  logic     ser_i,
  output logic     ser_o,
  output logic     pin_o
);

  logic upd;

  // latch stays data source while drivers are disabled
  assign pin_o = (ctrl_i.test_mode || out_dis_i) ? upd : core_i;

  bscan_stage u_stage (
    .tck_i  (tck_i),
    .rst_ni (rst_ni),
    .ctrl_i (ctrl_i),
    .cap_i  (core_i),
    .ser_i  (ser_i),
    .ser_o  (ser_o),
    .upd_o  (upd)
  );

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int N_IN  = 8,
  parameter int M_OUT = 8
) (
  input  logic             tck_i,
  input  logic             rst_ni,
  input  logic             capture_dr_i,
  input  logic             shift_dr_i,
  input  logic             update_dr_i,
  input  logic             test_mode_i,
  input  logic             out_dis_i,
  input  logic             tdi_i,
  output logic             tdo_o,
  input  logic [N_IN-1:0]  pin_in_i,
  output logic [N_IN-1:0]  core_in_o,
  input  logic [M_OUT-1:0] core_out_i,
  output logic [M_OUT-1:0] pin_out_o,
  output logic             pin_oe_o
);

  localparam int LEN = N_IN + M_OUT;

  bs_ctrl_t    ctrl;
  logic [LEN:0] ser;

  assign ctrl.capture   = capture_dr_i;
  assign ctrl.shift     = shift_dr_i;
  assign ctrl.update    = update_dr_i;
  assign ctrl.test_mode = test_mode_i;

  assign ser[0]   = tdi_i;
  assign tdo_o    = ser[LEN];
  assign pin_oe_o = ~out_dis_i;

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    bscan_in_cell u_cell (
      .tck_i  (tck_i),
      .rst_ni (rst_ni),
      .ctrl_i (ctrl),
      .pin_i  (pin_in_i[i]),
      .ser_i  (ser[i]),
      .ser_o  (ser[i+1]),
      .core_o (core_in_o[i])
    );
  end

  for (genvar j = 0; j < M_OUT; j++) begin : g_out
    bscan_out_cell u_cell (
      .tck_i     (tck_i),
      .rst_ni    (rst_ni),
      .ctrl_i    (ctrl),
      .out_dis_i (out_dis_i),
      .core_i    (core_out_i[j]),
      .ser_i     (ser[N_IN+j]),
      .ser_o     (ser[N_IN+j+1]),
      .pin_o     (pin_out_o[j])
    );
  end

endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
  parameter int N_IN  = 8,
  parameter int M_OUT = 8
) (
  input logic             tck_i,
  input logic             rst_ni,
  input logic             capture_dr_i,
  input logic             shift_dr_i,
  input logic             update_dr_i,
  input logic             test_mode_i,
  input logic             out_dis_i,
  input logic             tdo_o,
  input logic [N_IN-1:0]  pin_in_i,
  input logic [N_IN-1:0]  core_in_o,
  input logic [M_OUT-1:0] core_out_i,
  input logic [M_OUT-1:0] pin_out_o,
  input logic             pin_oe_o
);

  AST_NORMAL_PASS: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!test_mode_i && !out_dis_i) |-> (core_in_o == pin_in_i && pin_out_o == core_out_i && pin_oe_o)); // R2

  AST_CAPTURE_LAST_OUT: assert property (@(posedge tck_i) disable iff (!rst_ni)
    capture_dr_i |=> (tdo_o == $past(core_out_i[M_OUT-1]))); // R4

  AST_LATCH_HOLD: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (test_mode_i && $past(test_mode_i) && !update_dr_i) |-> ($stable(core_in_o) && $stable(pin_out_o))); // R7

  AST_DISABLE_OE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    out_dis_i |-> !pin_oe_o); // R9

  AST_SR_HOLD: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!capture_dr_i && !shift_dr_i) |=> $stable(tdo_o)); // R11

endmodule

bind bscan_chain bscan_chain_chk #(.N_IN(N_IN), .M_OUT(M_OUT)) u_chk (
  .tck_i        (tck_i),
  .rst_ni       (rst_ni),
  .capture_dr_i (capture_dr_i),
  .shift_dr_i   (shift_dr_i),
  .update_dr_i  (update_dr_i),
  .test_mode_i  (test_mode_i),
  .out_dis_i    (out_dis_i),
  .tdo_o        (tdo_o),
  .pin_in_i     (pin_in_i),
  .core_in_o    (core_in_o),
  .core_out_i   (core_out_i),
  .pin_out_o    (pin_out_o),
  .pin_oe_o     (pin_oe_o)
);

// File: tb/bscan_chain_test.sv
module bscan_chain_test;

  localparam int NI  = 3;
  localparam int MO  = 2;
  localparam int L   = NI + MO;

  logic          tck = 1'b0;
  logic          rst_ni = 1'b0;
  logic          capture_dr = 1'b0;
  logic          shift_dr = 1'b0;
  logic          update_dr = 1'b0;
  logic          test_mode = 1'b0;
  logic          out_dis = 1'b0;
  logic          tdi = 1'b0;
  logic          tdo;
  logic [NI-1:0] pin_in = '0;
  logic [NI-1:0] core_in;
  logic [MO-1:0] core_out = '0;
  logic [MO-1:0] pin_out;
  logic          pin_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 tck = ~tck;

  bscan_chain #(.N_IN(NI), .M_OUT(MO)) uut (
    .tck_i        (tck),
    .rst_ni       (rst_ni),
    .capture_dr_i (capture_dr),
    .shift_dr_i   (shift_dr),
    .update_dr_i  (update_dr),
    .test_mode_i  (test_mode),
    .out_dis_i    (out_dis),
    .tdi_i        (tdi),
    .tdo_o        (tdo),
    .pin_in_i     (pin_in),
    .core_in_o    (core_in),
    .core_out_i   (core_out),
    .pin_out_o    (pin_out),
    .pin_oe_o     (pin_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge tck);
    #2;
  endtask

  // shifts vin in (index L-1 first), returns what came out, indexed by chain position
  task automatic shift_vec(input logic [L-1:0] vin, output logic [L-1:0] vout);
    shift_dr = 1'b1;
    for (int j = 0; j < L; j++) begin
      tdi = vin[L-1-j];
      vout[L-1-j] = tdo;
      step();
    end
    shift_dr = 1'b0;
  endtask

  task automatic do_update();
    update_dr = 1'b1;
    step();
    update_dr = 1'b0;
  endtask

  task automatic do_capture();
    capture_dr = 1'b1;
    step();
    capture_dr = 1'b0;
  endtask

  initial begin
    logic [L-1:0] got;
    logic [L-1:0] dummy;
    logic [L-1:0] w;
    logic [NI-1:0] p;
    logic [MO-1:0] c;
    step(); step(); step();
    rst_ni = 1'b1;
    test_mode = 1'b1;
    #1;
    chk("R1 core_in", core_in, 0);
    chk("R1 pin_out", pin_out, 0);
    chk("R1 tdo", tdo, 0);
    step();

    for (int v = 0; v < (1 << L); v++) begin
      p = NI'((v * 3 + 1) & 7);
      c = MO'((v ^ (v >> 2)) & 3);
      w = L'((v * 7 + 3) & 31);
      test_mode = 1'b0;
      pin_in    = p;
      core_out  = c;
      #1;
      chk("R2 core_in", core_in, p);
      chk("R2 pin_out", pin_out, c);
      chk("R2 oe", pin_oe, 1);
      step();
      // preload in normal mode
      shift_vec(L'(v), dummy);
      do_update();
      chk("R8 core_in passthru", core_in, p);
      chk("R8 pin_out passthru", pin_out, c);
      test_mode = 1'b1;
      #1;
      chk("R3/R8 core_in", core_in, v & 7);
      chk("R3/R8 pin_out", pin_out, (v >> NI) & 3);
      // output-disable in normal mode still drives from latches
      test_mode = 1'b0;
      out_dis   = 1'b1;
      #1;
      chk("R9 oe", pin_oe, 0);
      chk("R9 pin_out", pin_out, (v >> NI) & 3);
      chk("R9 core_in", core_in, p);
      out_dis   = 1'b0;
      test_mode = 1'b1;
      step();
      // internal-test capture
      do_capture();
      shift_vec(w, got);
      chk("R4/R6 captured", got, {c, ~NI'(v)});
      chk("R7 core_in before update", core_in, v & 7);
      chk("R7 pin_out before update", pin_out, (v >> NI) & 3);
      do_update();
      chk("R7 core_in after update", core_in, w[NI-1:0]);
      chk("R7 pin_out after update", pin_out, w[L-1:NI]);
      // normal-mode capture
      test_mode = 1'b0;
      do_capture();
      shift_vec(dummy, got);
      chk("R5 captured", got, {c, p});
    end

    // capture beats shift, then hold across idle edges
    test_mode = 1'b1;
    pin_in    = 3'b010;
    core_out  = 2'b01;
    shift_vec(5'b10110, dummy);
    do_update();
    capture_dr = 1'b1;
    shift_dr   = 1'b1;
    tdi        = 1'b1;
    step();
    capture_dr = 1'b0;
    shift_dr   = 1'b0;
    step(); step(); step();
    shift_vec(5'b00000, got);
    chk("R10/R11 captured", got, {2'b01, 3'b001});

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule